// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

This block is a synthesizable stand-in for a word-organized static memory. The memory holds 24-bit words. The word is cut into three 8-bit lanes, and each lane has its own active-low select. Write-enable and output-enable are active low and shared by all three lanes. Each lane decodes its own control state on its own. A selected lane takes part in a write or a read. A deselected lane stays silent and keeps its contents.

The data bus is split into pad-side signals: an input word `dq_i`, an output word `dq_o` and one output-enable per lane, `dq_oe`. The pad ring joins these three signals into the bidirectional pins. A lane whose `dq_oe` bit is low counts as high impedance. Reads are combinational from the address. Writes are captured on the rising edge of the system clock.

The array depth is a parameter. The address width is derived from the depth. An asynchronous active-low reset is released synchronously, and it blocks writes until that release completes.

Top module: `sram_lanes`

## Requirements
- R1: Lane k covers data bits 8k to 8k+7. Select bit `sel_n[0]` governs bits 7:0, `sel_n[1]` governs bits 15:8 and `sel_n[2]` governs bits 23:16, and each select affects only its own lane.
- R2: On a rising clock edge where `sel_n[k]` is 0 and `we_n` is 0, lane k of `dq_i` is stored at `addr`.
- R3: A lane whose `sel_n` bit is 1 during a write keeps the contents it already held at that address.
- R4: When `sel_n[k]` is 0, `we_n` is 1 and `oe_n` is 0, `dq_oe[k]` is 1 and lane k of `dq_o` carries the stored lane at `addr`, in the same cycle the inputs change.
- R5: A lane whose `sel_n` bit is 1 has its `dq_oe` bit at 0 (high impedance).
- R6: During a read (`we_n` = 1) with `oe_n` = 1, all `dq_oe` bits are 0.
- R7: While `we_n` is 0, `oe_n` is ignored and all `dq_oe` bits are 0.
- R8: No write takes place while `rst_n` is low, or during the first two rising edges after `rst_n` rises. Stored contents survive a reset.
- R9: Every address from 0 to DEPTH-1 is a separate word. `addr` is clog2(DEPTH) bits wide, which is 10 bits for the default depth of 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; writes are captured on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | ADDR_W | Word address |
| sel_n | input | 3 | Active-low lane selects, one per byte lane |
| we_n | input | 1 | Active-low write enable, shared by all lanes |
| oe_n | input | 1 | Active-low output enable, shared by all lanes |
| dq_i | input | 24 | Data arriving from the pins |
| dq_o | output | 24 | Read data going to the pins |
| dq_oe | output | 3 | Per-lane pin drive enable; 0 means high impedance |

## Verification
The tests start with full-word writes of different patterns at address 0, address 1 and the top address. These show whether the lanes or the addresses alias one another. Single-lane writes over a known word then show whether a lane writes into its neighbours. Single-lane reads show whether a select gates the correct bits. Reads with output disabled, and writes with output enabled, separate the output-enable path from the write-enable path. A write attempted during reset shows whether the write gating follows the reset release.

// File: rtl/sram_lanes_pkg.sv
package sram_lanes_pkg;
  localparam int LANES  = 3;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    LANE_OFF   = 2'd0,
    LANE_WRITE = 2'd1,
    LANE_READ  = 2'd2,
    LANE_QUIET = 2'd3
  } lane_mode_t;
endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rdy
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rdy = sync_q[STAGES-1];
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lanes_pkg::*;
(
  input  logic sel_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic wr_ok,
  output logic wr_en,
  output logic drv_en
);
  lane_mode_t mode;

  always_comb begin
    if (sel_n)     mode = LANE_OFF;
    else if (!we_n) mode = LANE_WRITE;
    else if (!oe_n) mode = LANE_READ;
    else           mode = LANE_QUIET;
  end

  always_comb begin
    wr_en  = (mode == LANE_WRITE) && wr_ok;
    drv_en = (mode == LANE_READ);
  end
endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[addr] <= wdata;
  end

  assign rdata = store[addr];
endmodule

// File: rtl/sram_lanes.sv
module sram_lanes
  import sram_lanes_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  sel_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [WORD_W-1:0] dq_i,
  output logic [WORD_W-1:0] dq_o,
  output logic [LANES-1:0]  dq_oe
);
  logic             wr_ok;
  logic [LANES-1:0] wr_en;
  logic [LANES-1:0] drv_en;

  sram_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rdy   (wr_ok)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sram_lane_ctrl u_ctrl (
      .sel_n  (sel_n[k]),
      .we_n   (we_n),
      .oe_n   (oe_n),
      .wr_ok  (wr_ok),
      .wr_en  (wr_en[k]),
      .drv_en (drv_en[k])
    );

    sram_lane_bank #(.DEPTH(DEPTH), .WIDTH(LANE_W)) u_bank (
      .clk   (clk),
      .wr_en (wr_en[k]),
      .addr  (addr),
      .wdata (dq_i[k*LANE_W +: LANE_W]),
      .rdata (dq_o[k*LANE_W +: LANE_W])
    );
  end

  assign dq_oe = drv_en;
endmodule

// File: rtl/sram_lanes_chk.sv
module sram_lanes_chk
  import sram_lanes_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [LANES-1:0]  sel_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [WORD_W-1:0] dq_i,
  input logic [WORD_W-1:0] dq_o,
  input logic [LANES-1:0]  dq_oe,
  input logic              wr_ok,
  input logic [LANES-1:0]  wr_en
);
  // R7
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (dq_oe == '0));

  // R6
  read_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n && oe_n) |-> (dq_oe == '0));

  // R8
  reset_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ok |-> (wr_en == '0));

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    // R5
    lane_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n[k] |-> !dq_oe[k]);

    // R4
    lane_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_n[k] && we_n && !oe_n) |-> dq_oe[k]);

    // R2
    lane_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[k] |=> ((addr != $past(addr)) ||
                    (dq_o[k*LANE_W +: LANE_W] == $past(dq_i[k*LANE_W +: LANE_W]))));

    // R3
    lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n[k] |=> ((addr != $past(addr)) ||
                    (dq_o[k*LANE_W +: LANE_W] == $past(dq_o[k*LANE_W +: LANE_W]))));
  end
endmodule

bind sram_lanes sram_lanes_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .addr  (addr),
  .sel_n (sel_n),
  .we_n  (we_n),
  .oe_n  (oe_n),
  .dq_i  (dq_i),
  .dq_o  (dq_o),
  .dq_oe (dq_oe),
  .wr_ok (wr_ok),
  .wr_en (wr_en)
);

// File: tb/sim_sram_lanes.sv
`timescale 1ns/1ps
module sim_sram_lanes;
  localparam int DEPTH  = 1024;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic [2:0]        sel_n;
  logic              we_n;
  logic              oe_n;
  logic [23:0]       dq_i;
  logic [23:0]       dq_o;
  logic [2:0]        dq_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sram_lanes #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n),
    .we_n(we_n), .oe_n(oe_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %06h expected %06h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    sel_n = 3'b111; we_n = 1'b1; oe_n = 1'b1; dq_i = '0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [2:0] s, input logic [23:0] d);
    @(negedge clk);
    addr = a; sel_n = s; we_n = 1'b0; oe_n = 1'b1; dq_i = d;
    @(posedge clk);
    idle();
  endtask

  // Read with given selects; compares enables and data on enabled lanes.
  task automatic rd(input string req, input logic [ADDR_W-1:0] a, input logic [2:0] s,
                    input logic [2:0] exp_oe, input logic [23:0] exp_d);
    logic [23:0] mask;
    @(negedge clk);
    addr = a; sel_n = s; we_n = 1'b1; oe_n = 1'b0;
    #2;
    mask = {{8{exp_oe[2]}}, {8{exp_oe[1]}}, {8{exp_oe[0]}}};
    check({req, " oe"}, {21'd0, dq_oe}, {21'd0, exp_oe});
    check({req, " data"}, dq_o & mask, exp_d & mask);
    idle();
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; addr = '0; sel_n = 3'b000; we_n = 1'b1; oe_n = 1'b1; dq_i = '0;
    repeat (2) @(posedge clk);
    #2;
    check("R6 reset outputs off", {21'd0, dq_oe}, 24'd0);
    @(negedge clk); rst_n = 1'b1; sel_n = 3'b111;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_full_words();
    wr(10'd0, 3'b000, 24'hA5C3E1);
    wr(10'd1, 3'b000, 24'h5A3C1E);
    wr(10'(DEPTH-1), 3'b000, 24'hFFFFFF);
    rd("R2 R4 R9 addr0", 10'd0, 3'b000, 3'b111, 24'hA5C3E1);
    rd("R2 R4 R9 addr1", 10'd1, 3'b000, 3'b111, 24'h5A3C1E);
    rd("R9 top addr", 10'(DEPTH-1), 3'b000, 3'b111, 24'hFFFFFF);
  endtask

  task automatic t_lane_write();
    wr(10'd20, 3'b000, 24'hAABBCC);
    wr(10'd20, 3'b101, 24'h123456);
    rd("R3 middle lane write", 10'd20, 3'b000, 3'b111, 24'hAA34CC);
    wr(10'd20, 3'b011, 24'h99FFFF);
    rd("R1 R3 top lane write", 10'd20, 3'b000, 3'b111, 24'h9934CC);
  endtask

  task automatic t_lane_read();
    rd("R1 R5 lane0 only", 10'd20, 3'b110, 3'b001, 24'h0000CC);
    rd("R1 R5 lane2 only", 10'd20, 3'b011, 3'b100, 24'h990000);
    rd("R5 none selected", 10'd20, 3'b111, 3'b000, 24'h000000);
  endtask

  task automatic t_oe_off();
    @(negedge clk);
    addr = 10'd20; sel_n = 3'b000; we_n = 1'b1; oe_n = 1'b1;
    #2;
    check("R6 read with oe_n high", {21'd0, dq_oe}, 24'd0);
    idle();
  endtask

  task automatic t_write_oe_on();
    @(negedge clk);
    addr = 10'd30; sel_n = 3'b000; we_n = 1'b0; oe_n = 1'b0; dq_i = 24'h0F1E2D;
    #2;
    check("R7 write ignores oe_n", {21'd0, dq_oe}, 24'd0);
    @(posedge clk);
    idle();
    rd("R7 write with oe low stored", 10'd30, 3'b000, 3'b111, 24'h0F1E2D);
  endtask

  task automatic t_no_select_write();
    wr(10'd30, 3'b111, 24'hDEAD00);
    rd("R3 R5 write without select", 10'd30, 3'b000, 3'b111, 24'h0F1E2D);
  endtask

  task automatic t_reset_blocks_write();
    wr(10'd5, 3'b000, 24'h111111);
    @(negedge clk);
    rst_n = 1'b0; addr = 10'd5; sel_n = 3'b000; we_n = 1'b0; dq_i = 24'h999999;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; sel_n = 3'b111; we_n = 1'b1;
    repeat (3) @(posedge clk);
    rd("R8 write held in reset", 10'd5, 3'b000, 3'b111, 24'h111111);
  endtask

  initial begin
    t_reset_state();
    t_full_words();
    t_lane_write();
    t_lane_read();
    t_oe_off();
    t_write_oe_on();
    t_no_select_write();
    t_reset_blocks_write();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule